// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block supervises software with a down-counter that is loaded from a programmable value. When the counter runs out for the first time, the block raises an interrupt and reloads itself. Software must then service that interrupt by pulsing the kick input. If the counter runs out a second time and the interrupt is still pending, the block raises a reset request. Choosing which reset domain is affected, and producing the system reset itself, are left to the logic downstream.

While the enable input is low, the counter follows the load value and both outputs are low. After enable rises, the counter decrements once per clock. When it reaches zero, the next clock edge counts as an expiry and reloads the counter. With a load value L, one timeout period therefore lasts L+1 clock edges.

Top module: `wdog_escalate`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, irq and rst_req are both 0.
- R2: With load value L (not 0) and enable sampled high from a given edge, irq is 0 after L edges and becomes 1 on edge L+1.
- R3: After each expiry, the counter reloads automatically. After a kick, the next expiry raises irq again exactly L+1 edges after the previous expiry.
- R4: If irq is still 1 when a second expiry occurs, rst_req becomes 1 on that edge, which is edge 2(L+1) when no kick is given. irq stays 1.
- R5: A kick sampled high while irq is 1, on an edge that is not an expiry, clears irq on that edge. The next expiry is then a first timeout: irq rises and rst_req stays 0.
- R6: Once rst_req is 1, it stays 1 while enable is high, including when kick is pulsed.
- R7: A change to load_val while the counter is running does not change the current countdown. It takes effect at the next reload.
- R8: A load value of 0 behaves as a load value of 1, which gives a period of 2 edges.
- R9: An edge that samples enable low clears irq and rst_req and reloads the counter. A later enable restarts a full L+1 period.
- R10: A kick sampled on the same edge as an expiry counts as servicing the pending interrupt. irq stays 1 for the new timeout and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the watchdog when high; low clears and reloads |
| load_val | input | CNT_W | Reload value (0 acts as 1) |
| kick | input | 1 | Clears the pending timeout interrupt |
| irq | output | 1 | Timeout interrupt, pending flag |
| rst_req | output | 1 | Sticky reset request |

## Verification
The assertions assume that enable, kick and load_val are synchronous to clk and stable around each rising edge. The reload check compares the reloaded count with the load value sampled on the expiry edge. The kick property assumes that a kick on an expiry edge is covered by the escalation rule, not by the clear rule, so it excludes that edge. The bench changes every input one nanosecond after a rising edge and samples the outputs at that same point. This keeps each input constant across the edge that consumes it, and it keeps every kick, load change and enable change aligned to a known edge count.

// File: rtl/wdog_escalate.sv
module wdog_escalate #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] load_val,
  input  logic             kick,
  output logic             irq,
  output logic             rst_req
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;
  logic             expire;
  logic             pending;
  logic             escalate;

  assign reload   = (load_val == '0) ? ONE : load_val;
  assign expire   = enable && (cnt == '0);
  assign escalate = expire && pending && !kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= ONE;
    else if (!enable || expire)
      cnt <= reload;
    else
      cnt <= cnt - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pending <= 1'b0;
    else if (!enable)
      pending <= 1'b0;
    else if (expire)
      pending <= 1'b1;
    else if (kick)
      pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_req <= 1'b0;
    else if (!enable)
      rst_req <= 1'b0;
    else if (escalate)
      rst_req <= 1'b1;
  end

  assign irq = pending;

endmodule

module wdog_escalate_props #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [CNT_W-1:0] load_val,
  input logic             kick,
  input logic             irq,
  input logic             rst_req,
  input logic [CNT_W-1:0] cnt
);

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  p_irq_on_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt == '0) |=> irq);

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt == '0) |=>
      (cnt == (($past(load_val) == '0) ? CNT_W'(1) : $past(load_val))));

  p_escalate_needs_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(irq));

  p_kick_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && kick && irq && cnt != '0) |=> !irq);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rst_req) |=> rst_req);

  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!irq && !rst_req));

  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!irq && !rst_req);
    end
  end

endmodule

bind wdog_escalate wdog_escalate_props #(.CNT_W(CNT_W)) u_props (
  .clk(clk), .rst_n(rst_n), .enable(enable), .load_val(load_val),
  .kick(kick), .irq(irq), .rst_req(rst_req), .cnt(cnt)
);

// File: tb/tb_wdog_escalate.sv
module tb_wdog_escalate;

  localparam int CNT_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic [CNT_W-1:0] load_val = '0;
  logic             kick = 1'b0;
  logic             irq;
  logic             rst_req;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  wdog_escalate #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .load_val(load_val),
    .kick(kick), .irq(irq), .rst_req(rst_req)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic idle(input logic [CNT_W-1:0] lv);
    enable = 1'b0;
    kick = 1'b0;
    load_val = lv;
    step(2);
  endtask

  task automatic t_reset;
    chk("R1 irq in reset", irq, 1'b0);
    chk("R1 rst_req in reset", rst_req, 1'b0);
    rst_n = 1'b1;
    step(3);
    chk("R1 irq idle", irq, 1'b0);
    chk("R1 rst_req idle", rst_req, 1'b0);
  endtask

  task automatic t_escalate;
    idle(5);
    enable = 1'b1;
    step(5);
    chk("R2 irq before expiry", irq, 1'b0);
    step(1);
    chk("R2 irq at edge L+1", irq, 1'b1);
    step(5);
    chk("R4 rst_req before second expiry", rst_req, 1'b0);
    step(1);
    chk("R4 rst_req at edge 2(L+1)", rst_req, 1'b1);
    chk("R4 irq held", irq, 1'b1);
    kick = 1'b1;
    step(1);
    kick = 1'b0;
    chk("R6 rst_req survives kick", rst_req, 1'b1);
    step(4);
    chk("R6 rst_req still set", rst_req, 1'b1);
    enable = 1'b0;
    step(1);
    chk("R9 irq cleared by disable", irq, 1'b0);
    chk("R9 rst_req cleared by disable", rst_req, 1'b0);
    enable = 1'b1;
    step(5);
    chk("R9 no irq before full period", irq, 1'b0);
    step(1);
    chk("R9 irq after full period", irq, 1'b1);
  endtask

  task automatic t_kick;
    idle(5);
    enable = 1'b1;
    step(6);
    chk("R2 irq raised", irq, 1'b1);
    kick = 1'b1;
    step(1);
    kick = 1'b0;
    chk("R5 kick clears irq", irq, 1'b0);
    step(4);
    chk("R3 no irq before reload period", irq, 1'b0);
    step(1);
    chk("R3 irq again after L+1", irq, 1'b1);
    chk("R5 no reset after serviced irq", rst_req, 1'b0);
  endtask

  task automatic t_coincide;
    idle(3);
    enable = 1'b1;
    step(4);
    chk("R2 irq at edge 4", irq, 1'b1);
    step(3);
    kick = 1'b1;
    step(1);
    kick = 1'b0;
    chk("R10 irq stays for new timeout", irq, 1'b1);
    chk("R10 no reset on serviced expiry", rst_req, 1'b0);
    step(4);
    chk("R10 reset after later unserviced expiry", rst_req, 1'b1);
  endtask

  task automatic t_reload_change;
    idle(10);
    enable = 1'b1;
    step(3);
    load_val = 4;
    step(7);
    chk("R7 current count unaffected", irq, 1'b0);
    step(1);
    chk("R7 irq at old period", irq, 1'b1);
    kick = 1'b1;
    step(1);
    kick = 1'b0;
    step(3);
    chk("R7 no irq before new period", irq, 1'b0);
    step(1);
    chk("R7 irq at new period", irq, 1'b1);
  endtask

  task automatic t_zero_load;
    idle(0);
    enable = 1'b1;
    step(1);
    chk("R8 irq low after 1 edge", irq, 1'b0);
    step(1);
    chk("R8 irq at edge 2", irq, 1'b1);
    step(1);
    chk("R8 rst_req low at edge 3", rst_req, 1'b0);
    step(1);
    chk("R8 rst_req at edge 4", rst_req, 1'b1);
  endtask

  initial begin
    #200000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_escalate();
    t_kick();
    t_coincide();
    t_reload_change();
    t_zero_load();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule